// File: doc/BRIEF.md
# BCH Error Location Bit Corrector

This block sits after an 8-bit-correcting BCH decoder that covers one 512-byte sector. The decoder delivers its results as three packed 32-bit location words and a status word. The status word holds a 4-bit error count and the top bits of the last location.

On a start strobe the block captures all four words and unpacks up to eight 13-bit bit indices. It adjusts each index by XOR with 3. For every in-range index among the first "count" slots, it flips the addressed bit of the sector buffer with a read, XOR, write sequence on a synchronous single-port byte RAM. The RAM is outside the block. Indices that land past the data area point into the ECC bytes, and the block skips them.

At the end the block raises `done` for one cycle. With it come the number of reported errors and a flag that marks the sector as beyond correction.

Top module: `bch_loc_fixer`

## Requirements
- R1: After reset `busy`, `done`, `uncorrectable`, `mem_rd_en` and `mem_wr_en` are all low, and the RAM port stays quiet while idle.
- R2: A count of 0 (status bits 13:10) gives `done` on the first clock edge after the edge that accepts `start`, with `fix_count` 0 and no RAM access.
- R3: A count above 8 writes nothing. It gives `done` one edge after start with `uncorrectable` high and `fix_count` 0.
- R4: The slot fields are unpacked as follows. s0 = w1[12:0]. s1 = w1[25:13]. s2 = {w2[6:0], w1[31:26]}. s3 = w2[19:7]. s4 = {w3[0], w2[31:20]}. s5 = w3[13:1]. s6 = w3[26:14]. s7 = {status[23:16], w3[31:27]}.
- R5: The bit position used for a slot is the slot field XOR 3.
- R6: For an adjusted position p below 4096, the block reads byte p>>3 and writes back that byte with bit p&7 inverted. The written byte differs from the read byte in exactly one bit and goes to the same address in the next cycle.
- R7: An adjusted position of 4096 or more causes no RAM read or write.
- R8: Only slots 0 to count-1 are applied, in slot order; a repeated position flips twice.
- R9: With a count n of 1 to 8, `done` comes 1+3n edges after the start edge. `fix_count` then equals n and `uncorrectable` is low. `done` lasts exactly one cycle.
- R10: A `start` pulse while `busy` is high is ignored, and the running job's inputs remain in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture the words and begin a job when idle |
| loc_w1 | input | 32 | Location word 1 |
| loc_w2 | input | 32 | Location word 2 |
| loc_w3 | input | 32 | Location word 3 |
| loc_stat | input | 32 | Status word: count at 13:10, slot 7 top bits at 23:16 |
| mem_addr | output | 9 | Byte address into the sector buffer |
| mem_rd_en | output | 1 | Read strobe; data is returned the next cycle |
| mem_rdata | input | 8 | Read data from the buffer |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 8 | Byte written back |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle completion pulse |
| fix_count | output | 4 | Reported error count, valid with done |
| uncorrectable | output | 1 | Count exceeded 8, valid with done |

## Verification
Every cycle, the assertions check the shape of each flip and the port traffic around it. A write must follow a read to the same address and change exactly one bit. The RAM must stay quiet while idle or when the count exceeds 8. `done` must be a single-cycle pulse, and a start during a job must leave the captured state alone. Other behaviours can only be shown by the bench scenarios, which compare the whole buffer and the completion latency against an arithmetic model. These are the correctness of the field unpacking, the XOR with 3, the 4096 cutoff and the limit to the first count slots.

// File: rtl/bch_loc_fixer.sv
module bch_loc_fixer #(
  parameter int SECTOR_BYTES = 512,
  parameter int MAX_FIX      = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] loc_w1,
  input  logic [31:0] loc_w2,
  input  logic [31:0] loc_w3,
  input  logic [31:0] loc_stat,
  output logic [8:0]  mem_addr,
  output logic        mem_rd_en,
  input  logic [7:0]  mem_rdata,
  output logic        mem_wr_en,
  output logic [7:0]  mem_wdata,
  output logic        busy,
  output logic        done,
  output logic [3:0]  fix_count,
  output logic        uncorrectable
);
  localparam int DATA_BITS = SECTOR_BYTES * 8;
  localparam int ADDR_W    = $clog2(SECTOR_BYTES);
  localparam int SLOT_W    = $clog2(MAX_FIX);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WR, S_NX, S_FIN} state_t;
  state_t state;

  logic [31:0]       w1_q, w2_q, w3_q;
  logic [7:0]        top7_q;
  logic [3:0]        cnt_q;
  logic              unc_q;
  logic [SLOT_W-1:0] slot;
  logic [12:0]       field [MAX_FIX];
  logic [12:0]       adj;
  logic              in_data;
  logic [3:0]        new_cnt;

  assign field[0] = w1_q[12:0];
  assign field[1] = w1_q[25:13];
  assign field[2] = {w2_q[6:0], w1_q[31:26]};
  assign field[3] = w2_q[19:7];
  assign field[4] = {w3_q[0], w2_q[31:20]};
  assign field[5] = w3_q[13:1];
  assign field[6] = w3_q[26:14];
  assign field[7] = {top7_q, w3_q[31:27]};

  assign adj       = field[slot] ^ 13'd3;
  assign in_data   = 32'(adj) < DATA_BITS;
  assign mem_addr  = adj[3 +: ADDR_W];
  assign mem_rd_en = (state == S_RD) && in_data;
  assign mem_wr_en = (state == S_WR) && in_data;
  assign mem_wdata = mem_rdata ^ (8'd1 << adj[2:0]);

  assign busy          = state != S_IDLE;
  assign done          = state == S_FIN;
  assign uncorrectable = done && unc_q;
  assign fix_count     = (done && !unc_q) ? cnt_q : 4'd0;
  assign new_cnt       = loc_stat[13:10];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      w1_q   <= '0;
      w2_q   <= '0;
      w3_q   <= '0;
      top7_q <= '0;
      cnt_q  <= '0;
      unc_q  <= 1'b0;
      slot   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          w1_q   <= loc_w1;
          w2_q   <= loc_w2;
          w3_q   <= loc_w3;
          top7_q <= loc_stat[23:16];
          cnt_q  <= new_cnt;
          slot   <= '0;
          unc_q  <= 32'(new_cnt) > MAX_FIX;
          state  <= (new_cnt == 4'd0 || 32'(new_cnt) > MAX_FIX) ? S_FIN : S_RD;
        end
        S_RD: state <= S_WR;
        S_WR: state <= S_NX;
        S_NX: begin
          if ({1'b0, slot} == cnt_q - 4'd1) state <= S_FIN;
          else begin
            slot  <= slot + 1'b1;
            state <= S_RD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd_en && !mem_wr_en)); // R1
  AST_UNC_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && unc_q) |-> (!mem_rd_en && !mem_wr_en)); // R3
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ($past(mem_rd_en) && mem_addr == $past(mem_addr))); // R6
  AST_ONE_BIT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ($countones(mem_wdata ^ mem_rdata) == 1)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(cnt_q) && $stable(w1_q) && $stable(w3_q))); // R10
endmodule

// File: tb/bch_loc_fixer_tb.sv
module bch_loc_fixer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] w1 = '0, w2 = '0, w3 = '0, st = '0;
  logic [8:0]  mem_addr;
  logic        mem_rd_en, mem_wr_en, busy, done, uncorrectable;
  logic [7:0]  mem_rdata, mem_wdata;
  logic [3:0]  fix_count;

  logic [7:0]  ram [512];
  logic [7:0]  expm [512];
  logic [12:0] rv [8];
  int          n_chk = 0, n_bad = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) ram[i] <= 8'(i * 37 + 5);
    end else begin
      if (mem_rd_en) mem_rdata <= ram[mem_addr];
      if (mem_wr_en) ram[mem_addr] <= mem_wdata;
    end
  end

  bch_loc_fixer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .loc_w1(w1), .loc_w2(w2), .loc_w3(w3), .loc_stat(st),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
    .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
    .busy(busy), .done(done), .fix_count(fix_count), .uncorrectable(uncorrectable)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic pack(input int cnt);
    w1 = {rv[2][5:0], rv[1], rv[0]};
    w2 = {rv[4][11:0], rv[3], rv[2][12:6]};
    w3 = {rv[7][4:0], rv[6], rv[5], rv[4][12]};
    st = {8'h00, rv[7][12:5], 2'b00, 4'(cnt), 10'h000};
  endtask

  task automatic model(input int cnt);
    if (cnt >= 1 && cnt <= 8)
      for (int k = 0; k < cnt; k++) begin
        int p;
        p = int'(rv[k] ^ 13'd3);
        if (p < 4096) expm[p >> 3][p & 7] = ~expm[p >> 3][p & 7];
      end
  endtask

  task automatic finish_check(input int cnt, input int cyc, input string tag);
    int elat, bad;
    elat = (cnt >= 1 && cnt <= 8) ? 1 + 3 * cnt : 1;
    chk(cyc == elat, $sformatf("R9 latency %s", tag), cyc, elat);
    chk(fix_count == ((cnt <= 8) ? cnt : 0), $sformatf("R2 R3 R9 count %s", tag), fix_count, (cnt <= 8) ? cnt : 0);
    chk(uncorrectable == (cnt > 8), $sformatf("R3 flag %s", tag), uncorrectable, cnt > 8);
    @(negedge clk);
    chk(!done, $sformatf("R9 pulse %s", tag), done, 0);
    bad = 0;
    for (int i = 0; i < 512; i++) if (ram[i] !== expm[i]) bad++;
    chk(bad == 0, $sformatf("R4 R5 R6 R7 R8 buffer %s", tag), bad, 0);
  endtask

  task automatic run(input int cnt, input bool_int_dummy, input string tag);
    int cyc;
    pack(cnt);
    model(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    finish_check(cnt, cyc, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) expm[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !uncorrectable && !mem_rd_en && !mem_wr_en, "R1 reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_rd_en && !mem_wr_en, "R1 idle", busy, 0);

    // R7 boundary: 4095 last data bit, 4096 first ECC bit; R5 field 3 -> bit 0
    rv[0] = 13'd4092; rv[1] = 13'd4099; rv[2] = 13'd3; rv[3] = 13'h1FFF;
    rv[4] = 13'd4095; rv[5] = 13'd8191; rv[6] = 13'd0; rv[7] = 13'd2048;
    run(8, 0, "boundary");

    // R4 each slot alone; others out of range
    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 8; k++) rv[k] = 13'h1FFF;
      rv[s] = 13'(s * 517 + 1234);
      run(8, 0, $sformatf("slot%0d", s));
    end

    // R8 duplicate position flips twice
    for (int k = 0; k < 8; k++) rv[k] = 13'd100;
    run(2, 0, "dup2");
    run(3, 0, "dup3");

    // R2 R3 R8 sweep over all counts
    for (int c = 0; c < 16; c++)
      for (int r = 0; r < 3; r++) begin
        for (int k = 0; k < 8; k++) begin
          lfsr = step(step(lfsr));
          rv[k] = 13'(lfsr % 16'd4600);
        end
        run(c, 0, $sformatf("sweep c%0d r%0d", c, r));
      end

    // R10 start during a job is ignored
    begin
      int cyc;
      for (int k = 0; k < 8; k++) rv[k] = 13'(k * 301 + 17);
      pack(8);
      model(8);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      repeat (4) begin @(negedge clk); cyc++; end
      w1 = 32'h0; w2 = 32'h0; w3 = 32'h0; st = {18'h0, 4'd1, 10'h0};
      start = 1'b1;
      @(negedge clk); cyc++;
      start = 1'b0;
      while (!done && cyc < 100) begin @(negedge clk); cyc++; end
      finish_check(8, cyc, "busy start R10");
      repeat (3) @(negedge clk);
      chk(!busy, "R10 no queued job", busy, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule